// File: doc/BRIEF.md
# AHB-Lite Burst Request Splitter

This block turns one processor-side memory request into a run of AHB-Lite master transfers. A request names a start address, a transfer count, a direction, an access size and a class. The block breaks the request into bus transactions that are only ever one, four or eight beats long. It drives the address and control signals of an AHB-Lite master port and moves from beat to beat whenever the bus accepts one.

Cache line fills go out as one wrapping eight-beat burst that starts at the critical word. Instruction fetches and line fills are always word-sized. Byte and halfword requests are sent as single transfers. Every address is aligned to its access size. When the last data phase has completed, the block raises a one-cycle completion pulse and becomes ready for the next request. Arbitration, split and retry responses and the caches are handled elsewhere.

Top module: `ahb_burst_splitter`

## Requirements
- R1: After reset, htrans is IDLE (2'b00), req_ready is 1 and req_done is 0.
- R2: A word request of classes data (2'b00) or write-back (2'b01) is split largest first. An eight-beat INCR8 (hburst 3'b101) is issued while at least 8 words remain, then a four-beat INCR4 (3'b011) while at least 4 remain, then SINGLE (3'b000) transfers. The address rises by 4 on each beat.
- R3: The first beat of every burst shows htrans NONSEQ (2'b10) and every later beat shows SEQ (2'b11). Bursts of one request follow each other with no IDLE cycle between them. htrans is IDLE when no beat is presented.
- R4: While a beat is presented and hready is low, haddr, htrans, hburst, hsize and hwrite keep their values into the next cycle.
- R5: A line fill (class 2'b11) is one WRAP8 burst (hburst 3'b100) of exactly eight word beats, whatever the requested count. It starts at the word-aligned request address, and each beat adds 4 modulo 32 inside the 32-byte aligned block.
- R6: A halfword access (hsize 3'b001) clears address bit 0. A word access (hsize 3'b010) clears address bits 1:0. A byte access (3'b000) keeps the address as given.
- R7: Byte (req_size 2'b00) and halfword (req_size 2'b01) requests are issued as req_words SINGLE transfers with NONSEQ. The address steps by 1 or by 2 bytes.
- R8: Instruction fetches (class 2'b10) and line fills use word size whatever req_size says. A req_size of 2'b11 is also treated as word.
- R9: req_ready is 1 only while no request is in progress. A request is taken on a rising edge where req_valid and req_ready are both 1. req_done is high for exactly one cycle: the first cycle after the final beat's address phase in which hready is high, which completes that beat's data phase.
- R10: A req_words of zero is treated as one transfer.
- R11: hwrite equals the request's req_write on every beat of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_words | input | CNT_W | Number of transfers (words for word size) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_class | input | 2 | 00 data, 01 write-back, 10 instruction fetch, 11 line fill |
| req_done | output | 1 | One-cycle pulse when the last data phase completes |
| haddr | output | ADDR_W | Bus address |
| htrans | output | 2 | Transfer type |
| hburst | output | 3 | Burst type |
| hsize | output | 3 | Transfer size |
| hwrite | output | 1 | Transfer direction |
| hready | input | 1 | Bus ready from the addressed slave |

## Verification
Address and control for a beat are due in the first cycle after the beat before it is accepted; the first beat is due one cycle after the request is taken. The bench sets hready for the coming edge just after each falling edge. About 1 ns later it compares every presented beat, stalled or not, with the head of the expected-beat queue, and it pops the head only when hready is high. req_done is due in the first cycle after the last pop in which hready is high. The monitor checks that it appears in that cycle and in no other.

// File: rtl/ahbs_pkg.sv
package ahbs_pkg;

  localparam logic [1:0] HTRANS_IDLE   = 2'b00;
  localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
  localparam logic [1:0] HTRANS_SEQ    = 2'b11;

  localparam logic [2:0] HBURST_SINGLE = 3'b000;
  localparam logic [2:0] HBURST_INCR4  = 3'b011;
  localparam logic [2:0] HBURST_WRAP8  = 3'b100;
  localparam logic [2:0] HBURST_INCR8  = 3'b101;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam logic [1:0] CLS_DATA   = 2'b00;
  localparam logic [1:0] CLS_WBACK  = 2'b01;
  localparam logic [1:0] CLS_IFETCH = 2'b10;
  localparam logic [1:0] CLS_LFILL  = 2'b11;

  localparam int LONG_BEATS  = 8;
  localparam int SHORT_BEATS = 4;
  localparam int BEAT_W      = $clog2(LONG_BEATS) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} seq_state_e;

endpackage

// File: rtl/ahbs_rst_sync.sv
module ahbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/ahbs_burst_pick.sv
module ahbs_burst_pick
  import ahbs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]  cnt,
  input  logic [1:0]        cls,
  input  logic [1:0]        size,
  output logic [2:0]        burst,
  output logic [BEAT_W-1:0] beats
);
  always_comb begin
    if (cls == CLS_LFILL) begin
      burst = HBURST_WRAP8;
      beats = BEAT_W'(LONG_BEATS);
    end else if (size != SZ_WORD) begin
      burst = HBURST_SINGLE;
      beats = BEAT_W'(1);
    end else if (cnt >= CNT_W'(LONG_BEATS)) begin
      burst = HBURST_INCR8;
      beats = BEAT_W'(LONG_BEATS);
    end else if (cnt >= CNT_W'(SHORT_BEATS)) begin
      burst = HBURST_INCR4;
      beats = BEAT_W'(SHORT_BEATS);
    end else begin
      burst = HBURST_SINGLE;
      beats = BEAT_W'(1);
    end
  end
endmodule

// File: rtl/ahbs_addr_unit.sv
module ahbs_addr_unit
  import ahbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] raw_addr,
  input  logic [1:0]        raw_size,
  output logic [ADDR_W-1:0] aligned,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [1:0]        cur_size,
  input  logic              wrap,
  output logic [ADDR_W-1:0] next_addr
);
  localparam int WRAP_LSB = $clog2(LONG_BEATS * 4);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] inc;

  always_comb begin
    aligned = raw_addr;
    case (raw_size)
      SZ_HALF: aligned[0]   = 1'b0;
      SZ_WORD: aligned[1:0] = 2'b00;
      default: aligned      = raw_addr;
    endcase
  end

  assign step = ADDR_W'(1) << cur_size;
  assign inc  = cur_addr + step;

  always_comb begin
    if (wrap) next_addr = {cur_addr[ADDR_W-1:WRAP_LSB], inc[WRAP_LSB-1:0]};
    else      next_addr = inc;
  end
endmodule

// File: rtl/ahb_burst_splitter.sv
module ahb_burst_splitter
  import ahbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_words,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_class,
  output logic              req_done,
  output logic [ADDR_W-1:0] haddr,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic [2:0]        hsize,
  output logic              hwrite,
  input  logic              hready
);
  localparam int WRAP_LSB = $clog2(LONG_BEATS * 4);

  logic rst_n_i;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [BEAT_W-1:0] beats_q, beats_d;
  logic [2:0]        burst_q, burst_d;
  logic [1:0]        size_q, size_d;
  logic [1:0]        cls_q, cls_d;
  logic              write_q, write_d;
  logic              first_q, first_d;
  logic              upd_en;

  logic [1:0]        eff_size;
  logic [CNT_W-1:0]  start_cnt;
  logic [CNT_W-1:0]  pick_cnt;
  logic [1:0]        pick_cls;
  logic [1:0]        pick_size;
  logic [2:0]        pick_burst;
  logic [BEAT_W-1:0] pick_beats;
  logic [ADDR_W-1:0] aligned_addr;
  logic [ADDR_W-1:0] next_addr;

  ahbs_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  // Fetches, fills and the reserved size code become word accesses.
  always_comb begin
    if (req_class == CLS_IFETCH || req_class == CLS_LFILL || req_size == 2'b11)
      eff_size = SZ_WORD;
    else
      eff_size = req_size;
  end

  always_comb begin
    if (req_class == CLS_LFILL)  start_cnt = CNT_W'(LONG_BEATS);
    else if (req_words == '0)    start_cnt = CNT_W'(1);
    else                         start_cnt = req_words;
  end

  // Burst choice: from the new request when idle, from the remainder otherwise.
  always_comb begin
    if (state_q == ST_IDLE) begin
      pick_cnt  = start_cnt;
      pick_cls  = req_class;
      pick_size = eff_size;
    end else begin
      pick_cnt  = remain_q - CNT_W'(1);
      pick_cls  = cls_q;
      pick_size = size_q;
    end
  end

  ahbs_burst_pick #(.CNT_W(CNT_W)) pick_i (
    .cnt   (pick_cnt),
    .cls   (pick_cls),
    .size  (pick_size),
    .burst (pick_burst),
    .beats (pick_beats)
  );

  ahbs_addr_unit #(.ADDR_W(ADDR_W)) addr_i (
    .raw_addr  (req_addr),
    .raw_size  (eff_size),
    .aligned   (aligned_addr),
    .cur_addr  (addr_q),
    .cur_size  (size_q),
    .wrap      (burst_q == HBURST_WRAP8),
    .next_addr (next_addr)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    beats_d  = beats_q;
    burst_d  = burst_q;
    size_d   = size_q;
    cls_d    = cls_q;
    write_d  = write_q;
    first_d  = first_q;
    upd_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          upd_en   = 1'b1;
          state_d  = ST_RUN;
          addr_d   = aligned_addr;
          remain_d = start_cnt;
          beats_d  = pick_beats;
          burst_d  = pick_burst;
          size_d   = eff_size;
          cls_d    = req_class;
          write_d  = req_write;
          first_d  = 1'b1;
        end
      end
      ST_RUN: begin
        if (hready) begin
          upd_en = 1'b1;
          if (remain_q == CNT_W'(1)) begin
            state_d = ST_DRAIN;
          end else begin
            addr_d   = next_addr;
            remain_d = remain_q - CNT_W'(1);
            if (beats_q == BEAT_W'(1)) begin
              beats_d = pick_beats;
              burst_d = pick_burst;
              first_d = 1'b1;
            end else begin
              beats_d = beats_q - BEAT_W'(1);
              first_d = 1'b0;
            end
          end
        end
      end
      ST_DRAIN: begin
        if (hready) begin
          upd_en  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: begin
        upd_en  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      beats_q  <= '0;
      burst_q  <= HBURST_SINGLE;
      size_q   <= SZ_WORD;
      cls_q    <= CLS_DATA;
      write_q  <= 1'b0;
      first_q  <= 1'b0;
    end else if (upd_en) begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      beats_q  <= beats_d;
      burst_q  <= burst_d;
      size_q   <= size_d;
      cls_q    <= cls_d;
      write_q  <= write_d;
      first_q  <= first_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign req_done  = (state_q == ST_DRAIN) && hready;
  assign haddr     = addr_q;
  assign hburst    = burst_q;
  assign hsize     = {1'b0, size_q};
  assign hwrite    = write_q;
  assign htrans    = (state_q != ST_RUN) ? HTRANS_IDLE :
                     (first_q ? HTRANS_NONSEQ : HTRANS_SEQ);

  // Stalled beat keeps address and control (R4)
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (htrans != HTRANS_IDLE && !hready) |=>
      (haddr == $past(haddr) && htrans == $past(htrans) && hburst == $past(hburst) &&
       hsize == $past(hsize) && hwrite == $past(hwrite)));

  // Presented addresses are aligned to the access size (R6)
  assert_addr_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    (htrans != HTRANS_IDLE) |->
      ((hsize != 3'b001 || !haddr[0]) && (hsize != 3'b010 || haddr[1:0] == 2'b00)));

  // Sub-word beats are never part of a burst (R7)
  assert_subword_single_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (htrans != HTRANS_IDLE && hsize[1] == 1'b0) |-> (hburst == HBURST_SINGLE && htrans == HTRANS_NONSEQ));

  // Wrapping beats stay inside their aligned block (R5)
  assert_wrap_in_block_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (htrans == HTRANS_SEQ && hburst == HBURST_WRAP8) |->
      (haddr[ADDR_W-1:WRAP_LSB] == $past(haddr[ADDR_W-1:WRAP_LSB])));

  // A SEQ beat always continues an active transfer (R3)
  assert_seq_continues_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    (htrans == HTRANS_SEQ) |-> ($past(htrans) != HTRANS_IDLE));

  // Completion is a single-cycle pulse followed by readiness (R9)
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    req_done |=> (!req_done && req_ready));

endmodule

// File: tb/ahb_burst_splitter_tb_top.sv
`timescale 1ns/100ps
module ahb_burst_splitter_tb_top;

  typedef struct {
    logic [1:0]  tr;
    logic [2:0]  bu;
    logic [31:0] ad;
    logic [2:0]  sz;
    logic        wr;
    string       tag;
  } beat_t;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_addr;
  logic [7:0]  req_words;
  logic        req_write;
  logic [1:0]  req_size;
  logic [1:0]  req_class;
  logic        req_done;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic [2:0]  hburst;
  logic [2:0]  hsize;
  logic        hwrite;
  logic        hready;

  beat_t exp_q[$];
  int    checks;
  int    failures;
  int    done_cnt;
  int    cycles;
  logic  stall_mode;
  logic  done_due;
  logic  mon_on;
  logic [7:0] lf;

  ahb_burst_splitter dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_words(req_words), .req_write(req_write),
    .req_size(req_size), .req_class(req_class), .req_done(req_done),
    .haddr(haddr), .htrans(htrans), .hburst(hburst), .hsize(hsize),
    .hwrite(hwrite), .hready(hready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        failures++;
        $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
        finish_run();
      end
    end
  end

  // Monitor: sets hready for the coming edge, then compares with the queue head.
  initial begin
    hready   = 1'b1;
    lf       = 8'h5b;
    done_due = 1'b0;
    done_cnt = 0;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      hready = stall_mode ? (lf[0] | lf[2]) : 1'b1;
      #1;
      if (mon_on) begin
        if (htrans != 2'b00) begin
          checks++;
          if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R3: unexpected beat, actual htrans=%b haddr=%h expected IDLE", htrans, haddr);
          end else begin
            beat_t e;
            e = exp_q[0];
            if (htrans !== e.tr || hburst !== e.bu || haddr !== e.ad || hsize !== e.sz || hwrite !== e.wr) begin
              failures++;
              $display("FAIL %s: actual tr=%b bu=%b ad=%h sz=%b wr=%b expected tr=%b bu=%b ad=%h sz=%b wr=%b",
                       e.tag, htrans, hburst, haddr, hsize, hwrite, e.tr, e.bu, e.ad, e.sz, e.wr);
            end
            if (hready) begin
              void'(exp_q.pop_front());
              if (exp_q.size() == 0) done_due = 1'b1;
              continue;
            end
          end
        end
        // R9: done exactly in the first ready cycle after the last beat
        if (done_due && hready) begin
          checks++;
          if (req_done !== 1'b1) begin
            failures++;
            $display("FAIL R9: done missing, actual=%b expected=1", req_done);
          end
          done_due = 1'b0;
          done_cnt++;
        end else if (req_done === 1'b1) begin
          checks++;
          failures++;
          done_cnt++;
          $display("FAIL R9: stray done, actual=1 expected=0 (queue=%0d)", exp_q.size());
        end
      end
    end
  end

  task automatic push_beat(logic [1:0] tr, logic [2:0] bu, logic [31:0] ad, logic [2:0] sz,
                           logic wr, string tag);
    beat_t b;
    b.tr = tr; b.bu = bu; b.ad = ad; b.sz = sz; b.wr = wr; b.tag = tag;
    exp_q.push_back(b);
  endtask

  // Driver: builds expected beats from the requirements, then issues the request.
  task automatic issue(logic [31:0] addr, logic [7:0] words, logic wr, logic [1:0] size,
                       logic [1:0] cls, string tag);
    logic [1:0]  es;
    logic [31:0] a;
    int          n;
    int          blen;
    logic [2:0]  bu;
    int          target;
    es = (cls == 2'b10 || cls == 2'b11 || size == 2'b11) ? 2'b10 : size;
    a  = addr;
    if (es == 2'b01) a[0]   = 1'b0;
    if (es == 2'b10) a[1:0] = 2'b00;
    if (cls == 2'b11) begin
      for (int i = 0; i < 8; i++)
        push_beat(i == 0 ? 2'b10 : 2'b11, 3'b100,
                  {a[31:5], 3'(a[4:2] + 3'(i)), 2'b00}, 3'b010, wr, tag);
    end else begin
      n = (words == 0) ? 1 : int'(words);
      while (n > 0) begin
        blen = (es != 2'b10) ? 1 : (n >= 8) ? 8 : (n >= 4) ? 4 : 1;
        bu   = (blen == 8) ? 3'b101 : (blen == 4) ? 3'b011 : 3'b000;
        for (int i = 0; i < blen; i++) begin
          push_beat(i == 0 ? 2'b10 : 2'b11, bu, a, {1'b0, es}, wr, tag);
          a = a + (32'd1 << es);
        end
        n -= blen;
      end
    end
    target = done_cnt + 1;
    @(negedge clk);
    #1;
    checks++;
    if (req_ready !== 1'b1) begin
      failures++;
      $display("FAIL R9: not ready while idle, actual=%b expected=1", req_ready);
    end
    req_valid = 1'b1; req_addr = addr; req_words = words; req_write = wr;
    req_size = size; req_class = cls;
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    checks++;
    if (req_ready !== 1'b0) begin
      failures++;
      $display("FAIL R9: ready during request, actual=%b expected=0", req_ready);
    end
    while (done_cnt < target) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL %s: beats left after done, actual=%0d expected=0", tag, exp_q.size());
      exp_q.delete();
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    checks = 0; failures = 0;
    stall_mode = 1'b0; mon_on = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_words = '0;
    req_write = 1'b0; req_size = 2'b10; req_class = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    checks++;
    if (htrans !== 2'b00 || req_ready !== 1'b1 || req_done !== 1'b0) begin
      failures++;
      $display("FAIL R1: actual htrans=%b ready=%b done=%b expected 00 1 0", htrans, req_ready, req_done);
    end
    mon_on = 1'b1;

    issue(32'h0000_1000, 8'd13, 1'b0, 2'b10, 2'b00, "R2 R3 split 8+4+1");
    issue(32'h0000_3000, 8'd12, 1'b1, 2'b10, 2'b01, "R2 R11 write-back 8+4");
    issue(32'h0000_300C, 8'd3,  1'b0, 2'b00, 2'b11, "R5 R8 line fill");
    issue(32'h0000_4003, 8'd3,  1'b1, 2'b01, 2'b00, "R6 R7 halfword");
    issue(32'h0000_5001, 8'd2,  1'b0, 2'b00, 2'b00, "R7 R6 byte");
    issue(32'h0000_6002, 8'd4,  1'b0, 2'b01, 2'b10, "R8 R6 fetch word");
    issue(32'h0000_7003, 8'd0,  1'b0, 2'b11, 2'b00, "R10 R8 zero count");

    stall_mode = 1'b1;
    issue(32'h0000_2004, 8'd7,  1'b1, 2'b10, 2'b00, "R4 R11 stalled 4+1+1+1");
    issue(32'h0000_8000, 8'd16, 1'b1, 2'b10, 2'b01, "R4 R2 stalled 8+8");
    issue(32'h0000_901C, 8'd8,  1'b0, 2'b10, 2'b11, "R4 R5 stalled fill");
    issue(32'h0000_A002, 8'd3,  1'b0, 2'b01, 2'b00, "R4 R7 stalled halfword");
    stall_mode = 1'b0;
    issue(32'h0000_B000, 8'd8,  1'b0, 2'b10, 2'b00, "R2 exact INCR8");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule